// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block sends fixed-length frames of words onto a single serial data line, most significant bit first. Software or an upstream engine loads words through a small write port into an internal transmit FIFO. Bit timing comes from a one-cycle bit-enable pulse in the system clock domain. A frame starts on the rising edge of an externally supplied frame sync that the block samples on those pulses. Each frame holds `FRAME_WORDS` words of `WORD_BITS` bits, and the next frame can start on the tick right after the last bit.

Three sticky status flags report problems and progress. The first is set when a word slot comes up and the FIFO has nothing to give. The second is set when a frame sync edge arrives while a frame is still in flight; that edge is ignored. The third marks the second bit of a chosen word slot. Each flag has its own enable, and the enabled flags are ORed onto one interrupt line.

After an underflow the block can respond in one of two ways. By default it sends zeros and leaves the FIFO untouched until the error flag is cleared. In continue mode it recovers by itself: it waits for new data and then resumes at the same word slot that underflowed, so the order of words within the frame is kept.

Top module: `framed_tx`

## Requirements
- R1: After reset `sdata`, `flags`, `irq` and `fifo_full` are all 0.
- R2: A rising edge of `fsync` sampled on a `bit_en` tick while idle starts a frame on that same tick. The frame sends `FRAME_WORDS` words from the FIFO, MSB first, one bit per tick. `sdata` is 0 whenever no frame is running.
- R3: When a word slot begins and the FIFO is empty, `flags[0]` (FIFO error) is set and the slot is sent as zeros.
- R4: With `cont_en` low and `flags[0]` set, every word slot is sent as zeros and the FIFO is not read. Words written meanwhile stay queued until `fifo_flush` discards them.
- R5: With `cont_en` high, after an underflow in slot k, the block sends zeros and reads nothing until slot k comes up again with the FIFO non-empty. It then resumes from slot k, whether or not `flags[0]` has been cleared.
- R6: An `fsync` rising edge on any tick of a running frame other than its final boundary tick is ignored: the frame continues unchanged and `flags[1]` (sync error) is set.
- R7: An `fsync` rising edge on the boundary tick that ends a frame starts the next frame with no gap and sets no sync error.
- R8: `flags[2]` (word start) is set on the tick that sends the second bit of the word whose slot index equals `word_sel`, and not on an earlier tick.
- R9: Each flag stays set until a cycle with the matching `flag_clr` bit high. Clearing one flag leaves the others unchanged, and a new set event in the same cycle wins over the clear.
- R10: `irq` is high exactly when some flag is set whose `irq_en` bit is also set.
- R11: `fifo_full` is high when the FIFO holds `FIFO_DEPTH` words. Writes while full are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per serial bit period |
| fsync | input | 1 | External frame sync, sampled on `bit_en` |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | WORD_BITS | FIFO write data |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH words |
| fifo_flush | input | 1 | Empties the FIFO and cancels a pending resume |
| cont_en | input | 1 | Continue-after-underflow mode |
| word_sel | input | $clog2(FRAME_WORDS) | Slot index watched by the word start flag |
| flag_clr | input | 3 | Write-one-to-clear strobes, bit order as `flags` |
| irq_en | input | 3 | Interrupt enables, bit order as `flags` |
| sdata | output | 1 | Serial data out |
| flags | output | 3 | {word start, sync error, FIFO error} |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. The line stays low while idle, no flag drops without its clear strobe, and the word start flag rises only on a bit tick. A full FIFO stays full unless it is read or flushed, and the FIFO is never read while an underflow is pending outside continue mode. Other behaviour can only be seen in the bench's directed frames. These cover the exact bit order, resuming at the same slot in continue mode, ignoring a mid-frame sync, back-to-back frames, the tick on which the word start flag sets, and dropping a write while full.

// File: rtl/framed_tx_pkg.sv
package framed_tx_pkg;
    localparam int FLAG_FIFO = 0;
    localparam int FLAG_SYNC = 1;
    localparam int FLAG_WORD = 2;
    localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/ftx_fifo.sv
module ftx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign rd_data = mem_q[st_q.rp];
    assign do_wr   = wr_en && !flush && !full;
    assign do_rd   = rd_en && !flush && !empty;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_wr) st_d.wp = wrap_inc(st_q.wp);
            if (do_rd) st_d.rp = wrap_inc(st_q.rp);
            case ({do_wr, do_rd})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wp] <= wr_data;
    end
endmodule

// File: rtl/ftx_sync_det.sv
module ftx_sync_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic fsync,
    output logic fs_edge
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = prev_q;
        if (bit_en) prev_d = fsync;
    end

    assign fs_edge = bit_en && fsync && !prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ftx_framer.sv
module ftx_framer #(
    parameter int WORD_BITS   = 8,
    parameter int FRAME_WORDS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_en,
    input  logic                           fs_edge,
    input  logic                           fifo_empty,
    input  logic [WORD_BITS-1:0]           fifo_rdata,
    input  logic                           flush,
    input  logic                           cont_en,
    input  logic                           fef_q,
    input  logic [$clog2(FRAME_WORDS)-1:0] word_sel,
    output logic                           pop,
    output logic                           sdata,
    output logic                           busy,
    output logic                           uflow,
    output logic                           sync_err,
    output logic                           word_start
);
    localparam int BCW = $clog2(WORD_BITS);
    localparam int WIW = $clog2(FRAME_WORDS);

    typedef struct packed {
        logic                 busy;
        logic                 hold;
        logic [WIW-1:0]       resume;
        logic [WIW-1:0]       word_idx;
        logic [BCW-1:0]       bit_cnt;
        logic [WORD_BITS-1:0] shreg;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic           last_bit, frame_end, load, take;
    logic [WIW-1:0] slot_next;

    assign last_bit  = (st_q.bit_cnt == BCW'(WORD_BITS - 1));
    assign frame_end = st_q.busy && last_bit && (st_q.word_idx == WIW'(FRAME_WORDS - 1));

    always_comb begin
        st_d       = st_q;
        load       = 1'b0;
        take       = 1'b0;
        slot_next  = '0;
        uflow      = 1'b0;
        sync_err   = 1'b0;
        word_start = 1'b0;

        if (bit_en) begin
            if (!st_q.busy || frame_end) begin
                if (fs_edge) begin
                    load      = 1'b1;
                    slot_next = '0;
                    st_d.busy = 1'b1;
                end else begin
                    st_d.busy  = 1'b0;
                    st_d.shreg = '0;
                end
            end else begin
                if (fs_edge) sync_err = 1'b1;
                if (last_bit) begin
                    load      = 1'b1;
                    slot_next = st_q.word_idx + 1'b1;
                end else begin
                    st_d.bit_cnt = st_q.bit_cnt + 1'b1;
                    st_d.shreg   = st_q.shreg << 1;
                    if (st_q.bit_cnt == '0 && st_q.word_idx == word_sel)
                        word_start = 1'b1;
                end
            end

            if (load) begin
                st_d.word_idx = slot_next;
                st_d.bit_cnt  = '0;
                if (!cont_en && fef_q) begin
                    take = 1'b0;
                end else if (st_q.hold) begin
                    if (slot_next == st_q.resume && !fifo_empty) begin
                        take      = 1'b1;
                        st_d.hold = 1'b0;
                    end
                end else if (fifo_empty) begin
                    uflow = 1'b1;
                    if (cont_en) begin
                        st_d.hold   = 1'b1;
                        st_d.resume = slot_next;
                    end
                end else begin
                    take = 1'b1;
                end
                st_d.shreg = take ? fifo_rdata : '0;
            end
        end

        if (flush) st_d.hold = 1'b0;
    end

    assign pop   = take;
    assign sdata = st_q.shreg[WORD_BITS-1];
    assign busy  = st_q.busy;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ftx_flags.sv
module ftx_flags
    import framed_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 uflow,
    input  logic                 sync_err,
    input  logic                 word_start,
    input  logic [NUM_FLAGS-1:0] clr,
    input  logic [NUM_FLAGS-1:0] ien,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 irq
);
    logic [NUM_FLAGS-1:0] set_v, flg_d, flg_q;

    always_comb begin
        set_v            = '0;
        set_v[FLAG_FIFO] = uflow;
        set_v[FLAG_SYNC] = sync_err;
        set_v[FLAG_WORD] = word_start;
        flg_d            = (flg_q & ~clr) | set_v;
    end

    assign flags = flg_q;
    assign irq   = |(flg_q & ien);

    always_ff @(posedge clk) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end
endmodule

// File: rtl/framed_tx.sv
module framed_tx
    import framed_tx_pkg::*;
#(
    parameter int WORD_BITS   = 8,
    parameter int FRAME_WORDS = 4,
    parameter int FIFO_DEPTH  = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bit_en,
    input  logic                           fsync,
    input  logic                           wr_en,
    input  logic [WORD_BITS-1:0]           wr_data,
    output logic                           fifo_full,
    input  logic                           fifo_flush,
    input  logic                           cont_en,
    input  logic [$clog2(FRAME_WORDS)-1:0] word_sel,
    input  logic [NUM_FLAGS-1:0]           flag_clr,
    input  logic [NUM_FLAGS-1:0]           irq_en,
    output logic                           sdata,
    output logic [NUM_FLAGS-1:0]           flags,
    output logic                           irq
);
    logic                 fs_edge, fifo_empty, fifo_pop, framer_busy;
    logic                 ev_uflow, ev_sync, ev_word;
    logic [WORD_BITS-1:0] fifo_rdata;

    ftx_fifo #(.DATA_W(WORD_BITS), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(fifo_pop), .rd_data(fifo_rdata),
        .empty(fifo_empty), .full(fifo_full)
    );

    ftx_sync_det sync_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .fsync(fsync), .fs_edge(fs_edge)
    );

    ftx_framer #(.WORD_BITS(WORD_BITS), .FRAME_WORDS(FRAME_WORDS)) framer_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fs_edge(fs_edge),
        .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata), .flush(fifo_flush),
        .cont_en(cont_en), .fef_q(flags[FLAG_FIFO]), .word_sel(word_sel),
        .pop(fifo_pop), .sdata(sdata), .busy(framer_busy),
        .uflow(ev_uflow), .sync_err(ev_sync), .word_start(ev_word)
    );

    ftx_flags flags_i (
        .clk(clk), .rst_n(rst_n), .uflow(ev_uflow), .sync_err(ev_sync),
        .word_start(ev_word), .clr(flag_clr), .ien(irq_en),
        .flags(flags), .irq(irq)
    );
endmodule

// File: rtl/framed_tx_chk.sv
module framed_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       fifo_flush,
    input logic       fifo_full,
    input logic       cont_en,
    input logic [2:0] flag_clr,
    input logic [2:0] flags,
    input logic       sdata,
    input logic       busy,
    input logic       pop
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdata); // R2

    AST_NO_POP_IN_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !cont_en) |-> !pop); // R4

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(flags) & ~$past(flag_clr) & ~flags) == 3'b000)); // R9

    AST_WORD_FLAG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(bit_en)); // R8

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !pop && !fifo_flush) |=> fifo_full); // R11
endmodule

bind framed_tx framed_tx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fifo_flush(fifo_flush),
    .fifo_full(fifo_full), .cont_en(cont_en), .flag_clr(flag_clr),
    .flags(flags), .sdata(sdata), .busy(framer_busy), .pop(fifo_pop)
);

// File: tb/framed_tx_tb_top.sv
`timescale 1ns/1ps
module framed_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0, fsync = 1'b0, wr_en = 1'b0, fifo_flush = 1'b0, cont_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] word_sel = 2'd2;
    logic [2:0] flag_clr = '0, irq_en = '0;
    logic       fifo_full, sdata, irq;
    logic [2:0] flags;
    int         n_checks = 0, n_err = 0;

    always #4 clk = ~clk;

    framed_tx #(.WORD_BITS(8), .FRAME_WORDS(4), .FIFO_DEPTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
        .fifo_flush(fifo_flush), .cont_en(cont_en), .word_sel(word_sel),
        .flag_clr(flag_clr), .irq_en(irq_en), .sdata(sdata),
        .flags(flags), .irq(irq)
    );

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic tick(logic fs);
        @(negedge clk); fsync = fs; bit_en = 1'b1;
        @(posedge clk); @(negedge clk); bit_en = 1'b0;
    endtask

    task automatic push(logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic clear_flags(logic [2:0] m);
        @(negedge clk); flag_clr = m;
        @(posedge clk); @(negedge clk); flag_clr = '0;
    endtask

    task automatic flush_fifo();
        @(negedge clk); fifo_flush = 1'b1;
        @(posedge clk); @(negedge clk); fifo_flush = 1'b0;
    endtask

    // Plays one frame (fsync edge on first tick), checking every bit; optional pushes during slot 3.
    task automatic play_frame(logic [3:0][7:0] ew, string rq, int npush, logic [7:0] p0, logic [7:0] p1);
        for (int t = 0; t < 32; t++) begin
            tick(t == 0);
            check(rq, sdata, ew[t/8][7 - (t%8)]);
            if (t == 24 && npush > 0) push(p0);
            if (t == 24 && npush > 1) push(p1);
        end
    endtask

    task automatic idle_tick_check(string rq);
        tick(1'b0);
        check(rq, sdata, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 sdata", sdata, 0);
        check("R1 flags", flags, 0);
        check("R1 irq", irq, 0);
        check("R1 full", fifo_full, 0);
    endtask

    task automatic t_basic_and_word_flag();
        logic [3:0][7:0] ew = {8'h3C, 8'h81, 8'h5A, 8'hA5};
        for (int i = 0; i < 4; i++) push(ew[i]);
        for (int t = 0; t < 32; t++) begin
            tick(t == 0);
            check("R2 data", sdata, ew[t/8][7 - (t%8)]);
            check("R8 word start timing", flags[2], (t >= 17));
        end
        idle_tick_check("R2 idle low");
        check("R2 no errors", flags[1:0], 2'b00);
    endtask

    task automatic t_sync_error();
        logic [3:0][7:0] ew = {8'hF0, 8'h0F, 8'hCC, 8'h33};
        clear_flags(3'b111);
        for (int i = 0; i < 4; i++) push(ew[i]);
        for (int t = 0; t < 32; t++) begin
            tick(t == 0 || t == 5 || t == 20);
            check("R6 frame undisturbed", sdata, ew[t/8][7 - (t%8)]);
        end
        idle_tick_check("R6 frame length kept");
        check("R6 sync error flag", flags[1], 1'b1);
        check("R6 no fifo error", flags[0], 1'b0);
    endtask

    task automatic t_irq();
        irq_en = 3'b000;
        @(negedge clk);
        check("R10 masked", irq, 1'b0);
        irq_en = 3'b010;
        @(negedge clk);
        check("R10 enabled", irq, 1'b1);
        clear_flags(3'b010);
        check("R9 cleared bit", flags[1], 1'b0);
        check("R9 other bit kept", flags[2], 1'b1);
        check("R10 after clear", irq, 1'b0);
        irq_en = 3'b000;
    endtask

    task automatic t_back_to_back();
        logic [3:0][7:0] a = {8'h04, 8'h03, 8'h02, 8'h01};
        logic [3:0][7:0] b = {8'h80, 8'h40, 8'h20, 8'h10};
        clear_flags(3'b111);
        for (int i = 0; i < 4; i++) push(a[i]);
        for (int i = 0; i < 4; i++) push(b[i]);
        play_frame(a, "R7 first frame", 0, 8'h00, 8'h00);
        play_frame(b, "R7 second frame", 0, 8'h00, 8'h00);
        idle_tick_check("R7 idle after");
        check("R7 no sync error", flags[1], 1'b0);
        check("R7 no underflow", flags[0], 1'b0);
    endtask

    task automatic t_underflow_stop();
        cont_en = 1'b0;
        flush_fifo(); clear_flags(3'b111);
        push(8'hB1); push(8'hB2);
        play_frame({8'h00, 8'h00, 8'hB2, 8'hB1}, "R3 underflow zeros", 1, 8'hC7, 8'h00);
        check("R3 fifo error flag", flags[0], 1'b1);
        play_frame({8'h00, 8'h00, 8'h00, 8'h00}, "R4 zeros while flagged", 0, 8'h00, 8'h00);
        idle_tick_check("R4 idle");
        clear_flags(3'b001);
        play_frame({8'h00, 8'h00, 8'h00, 8'hC7}, "R4 queued word kept", 0, 8'h00, 8'h00);
        idle_tick_check("R4 idle 2");
        flush_fifo(); clear_flags(3'b111);
        play_frame({8'h00, 8'h00, 8'h00, 8'h00}, "R4 flush emptied", 0, 8'h00, 8'h00);
        idle_tick_check("R4 idle 3");
        check("R4 flush underflow", flags[0], 1'b1);
        flush_fifo(); clear_flags(3'b111);
    endtask

    task automatic t_underflow_continue();
        cont_en = 1'b1;
        push(8'hD1); push(8'hD2);
        play_frame({8'h00, 8'h00, 8'hD2, 8'hD1}, "R5 first frame", 2, 8'hE3, 8'hE4);
        check("R5 flag set", flags[0], 1'b1);
        play_frame({8'hE4, 8'hE3, 8'h00, 8'h00}, "R5 resume at slot 2", 0, 8'h00, 8'h00);
        idle_tick_check("R5 idle");
        clear_flags(3'b001);
        check("R5 flag cleared", flags[0], 1'b0);
        cont_en = 1'b0;
        flush_fifo(); clear_flags(3'b111);
    endtask

    task automatic t_full();
        for (int i = 0; i < 8; i++) push(8'(8'h60 + i));
        check("R11 full at depth", fifo_full, 1'b1);
        push(8'h99);
        check("R11 still full", fifo_full, 1'b1);
        play_frame({8'h63, 8'h62, 8'h61, 8'h60}, "R11 order", 0, 8'h00, 8'h00);
        play_frame({8'h67, 8'h66, 8'h65, 8'h64}, "R11 order 2", 0, 8'h00, 8'h00);
        idle_tick_check("R11 idle");
        check("R11 drained", fifo_full, 1'b0);
        check("R11 no underflow", flags[0], 1'b0);
        play_frame({8'h00, 8'h00, 8'h00, 8'h00}, "R11 dropped write", 0, 8'h00, 8'h00);
        idle_tick_check("R11 idle 2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic_and_word_flag();
        t_sync_error();
        t_irq();
        t_back_to_back();
        t_underflow_stop();
        t_underflow_continue();
        t_full();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule